// File: doc/BRIEF.md
# Transparent Processor Sparing Manager

This block keeps the role table for a pool of physical processor units. Every unit holds one of four roles: a logical processor carrying a logical number, an assist processor carrying an assist index (index 0 is the master assist processor), an idle spare, or failed. The table is loaded from parameters at reset. Any unit's role and number can be read back at once through a query port.

When a failure report for a unit arrives, the manager works through it over a fixed number of cycles and then updates the table in a single step. A failed logical processor passes its logical number to the lowest-numbered spare, so software sees no change, and a restore-state request is raised for the new unit. A failed assist processor is replaced by a spare, keeping its assist index. If no spare remains and the master assist processor fails, the highest-numbered active logical processor is converted into the master assist processor, and the logical number it carried is reported as lost. A failed unit is retired for good and never chosen again.

Each outcome is reported as a one-cycle event. If a logical processor fails while no spare is left, a sticky unrecoverable flag is set. Moving saved state and telling the operating system about the change are left to other logic.

Top module: `proc_sparing_mgr`

## Requirements
- R1: After reset the table holds the parameter contents. In that state fail_ready is 1, and evt_valid, restore_req and unrecoverable are all 0. Role codes are 0 logical processor, 1 assist processor, 2 spare, 3 failed.
- R2: qry_role and qry_num show the table entry of qry_unit combinationally, in the same cycle.
- R3: A report is taken on a clock edge where fail_valid and fail_ready are both 1. After that edge, fail_ready stays 0 for exactly PROC_CYCLES cycles. A report held on fail_valid during that time is taken only after fail_ready returns to 1.
- R4: When a logical processor fails and a spare exists, the lowest-numbered spare becomes a logical processor with the failed unit's number. The event has kind 0, and restore_req pulses with it for the new unit.
- R5: A failed unit becomes role 3 and keeps it until reset; it is never chosen as a replacement. A report on a unit that has already failed changes nothing and produces no event.
- R6: When an assist processor fails and a spare exists, the lowest-numbered spare becomes an assist processor with the same assist index. The event has kind 1 and there is no restore_req.
- R7: When the master assist processor (index 0) fails and no spare exists, the highest-numbered logical processor becomes assist index 0. The event has kind 2, and evt_num carries the logical number that was lost.
- R8: When a logical processor fails and no spare exists, or the master assist processor fails with neither a spare nor a logical processor left, the unit is marked failed. The event has kind 3, and unrecoverable is set and stays set until reset.
- R9: When a spare fails, or a non-master assist processor fails and no spare exists, the unit is retired. The event has kind 4, and evt_new_unit equals evt_old_unit.
- R10: An event lasts exactly one cycle, in the cycle in which fail_ready returns to 1. In that cycle the query port already shows the updated table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fail_valid | input | 1 | A failure report is present |
| fail_unit | input | UW | Physical unit named in the report |
| fail_ready | output | 1 | Manager is idle and can take a report |
| qry_unit | input | UW | Physical unit to look up |
| qry_role | output | 2 | Role code of the queried unit |
| qry_num | output | NUM_W | Logical number or assist index of the queried unit |
| evt_valid | output | 1 | One-cycle remap event |
| evt_kind | output | 3 | Event kind code (0 to 4) |
| evt_old_unit | output | UW | Unit that failed |
| evt_new_unit | output | UW | Unit that took over the role, or the failed unit itself |
| evt_num | output | NUM_W | Number carried over, or the logical number lost |
| restore_req | output | 1 | Restore saved state on evt_new_unit |
| unrecoverable | output | 1 | Sticky flag: a logical processor was lost |

## Verification
Two functions meet in the commit cycle: the table update becomes visible on the query port, and the event pulse goes out. The bench points the query port at the unit it expects to change before each report. The scoreboard monitor then checks the queried role in the same cycle as the event it pops. The other collision is a report held on fail_valid while the manager is busy. The bench judges it by counting the cycles until that report is taken and by the order of the two events in the queue.

// File: rtl/sparing_pkg.sv
// Package: shared role and event codes for the processor sparing manager.
// Assumes: role codes are decoded by software through the query port, so
// their values are fixed.
package sparing_pkg;

    typedef enum logic [1:0] {
        ROLE_CP     = 2'd0,
        ROLE_ASSIST = 2'd1,
        ROLE_SPARE  = 2'd2,
        ROLE_FAILED = 2'd3
    } role_t;

    typedef enum logic [2:0] {
        EV_CP_SPARED      = 3'd0,
        EV_ASSIST_SPARED  = 3'd1,
        EV_ASSIST_FROM_CP = 3'd2,
        EV_CP_LOST        = 3'd3,
        EV_RETIRED        = 3'd4
    } evt_kind_t;

endpackage

// File: rtl/spare_role_table.sv
// Module: spare_role_table
// Holds one role and one number per physical unit. The entries load from
// parameters at reset. There are two write ports. The move port writes a
// new role and number into one unit. The fail port writes the failed role
// into another unit.
// Assumes: the sequencer never points both ports at the same unit in the
// same cycle.
module spare_role_table #(
    parameter int N  = 16,
    parameter int UW = 4,
    parameter int NW = 4,
    parameter logic [2*N-1:0]  INIT_ROLES = '0,
    parameter logic [NW*N-1:0] INIT_NUMS  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_en,
    input  logic [UW-1:0]        upd_unit,
    input  logic                 mov_en,
    input  logic [UW-1:0]        mov_unit,
    input  logic [1:0]           mov_role,
    input  logic [NW-1:0]        mov_num,
    output logic [N-1:0][1:0]    roles_o,
    output logic [N-1:0][NW-1:0] nums_o
);
    import sparing_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic [1:0]    role_q;
        logic [NW-1:0] num_q;

        // Entry update: load at reset, take a move, or take a failure.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                role_q <= INIT_ROLES[2*g +: 2];
                num_q  <= INIT_NUMS[NW*g +: NW];
            end else if (mov_en && (mov_unit == UW'(g))) begin
                role_q <= mov_role;
                num_q  <= mov_num;
            end else if (upd_en && (upd_unit == UW'(g))) begin
                role_q <= ROLE_FAILED;
            end
        end

        assign roles_o[g] = role_q;
        assign nums_o[g]  = num_q;

        // R5: once an entry has failed it never comes back.
        p_failed_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (role_q == ROLE_FAILED) |=> (role_q == ROLE_FAILED));
    end

    // R5: the replacement is never the unit being retired.
    p_no_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mov_en && upd_en) |-> (mov_unit != upd_unit));

endmodule

// File: rtl/spare_pick.sv
// Module: spare_pick
// Purely combinational search over the role table. It returns the
// lowest-numbered spare unit and the highest-numbered active logical
// processor.
// Assumes: role codes come from sparing_pkg.
module spare_pick #(
    parameter int N  = 16,
    parameter int UW = 4
) (
    input  logic [N-1:0][1:0] roles_i,
    output logic              spare_found,
    output logic [UW-1:0]     spare_idx,
    output logic              cp_found,
    output logic [UW-1:0]     cp_idx
);
    import sparing_pkg::*;

    // Lowest spare: scan downward so the last hit is the smallest index.
    always_comb begin
        spare_found = 1'b0;
        spare_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (roles_i[i] == ROLE_SPARE) begin
                spare_found = 1'b1;
                spare_idx   = UW'(i);
            end
        end
    end

    // Highest logical processor: scan upward so the last hit is the largest index.
    always_comb begin
        cp_found = 1'b0;
        cp_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (roles_i[i] == ROLE_CP) begin
                cp_found = 1'b1;
                cp_idx   = UW'(i);
            end
        end
    end

endmodule

// File: rtl/spare_sequencer.sv
// Module: spare_sequencer
// Takes one failure report at a time and keeps it for PROC_CYCLES cycles.
// In the last of those cycles it decides the outcome. It then updates the
// table and emits a registered one-cycle event.
// Assumes: PROC_CYCLES >= 1. The role table does not change while busy.
module spare_sequencer #(
    parameter int N           = 16,
    parameter int UW          = 4,
    parameter int NW          = 4,
    parameter int PROC_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fail_valid,
    input  logic [UW-1:0]        fail_unit,
    output logic                 fail_ready,
    input  logic [N-1:0][1:0]    roles_i,
    input  logic [N-1:0][NW-1:0] nums_i,
    input  logic                 spare_found,
    input  logic [UW-1:0]        spare_idx,
    input  logic                 cp_found,
    input  logic [UW-1:0]        cp_idx,
    output logic                 upd_en,
    output logic [UW-1:0]        upd_unit,
    output logic                 mov_en,
    output logic [UW-1:0]        mov_unit,
    output logic [1:0]           mov_role,
    output logic [NW-1:0]        mov_num,
    output logic                 evt_valid,
    output logic [2:0]           evt_kind,
    output logic [UW-1:0]        evt_old_unit,
    output logic [UW-1:0]        evt_new_unit,
    output logic [NW-1:0]        evt_num,
    output logic                 restore_req,
    output logic                 unrecoverable
);
    import sparing_pkg::*;

    localparam int CW = $clog2(PROC_CYCLES + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [UW-1:0] cur_q;
    logic          commit;

    role_t         cur_role;
    logic [NW-1:0] cur_num;

    logic          dec_evt, dec_fail, dec_mov, dec_lost, dec_restore;
    evt_kind_t     dec_kind;
    logic [UW-1:0] dec_new;
    logic [NW-1:0] dec_num;
    role_t         dec_mov_role;
    logic [NW-1:0] dec_mov_num;

    evt_kind_t     evt_kind_q;
    logic          unrec_q;

    assign fail_ready = !busy_q;
    assign commit     = busy_q && (cnt_q == '0);
    assign cur_role   = role_t'(roles_i[cur_q]);
    assign cur_num    = nums_i[cur_q];

    // Report intake and processing countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cur_q  <= '0;
        end else if (!busy_q) begin
            if (fail_valid) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(PROC_CYCLES - 1);
                cur_q  <= fail_unit;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Outcome decision for the unit under processing.
    always_comb begin
        dec_evt      = 1'b0;
        dec_fail     = 1'b0;
        dec_mov      = 1'b0;
        dec_lost     = 1'b0;
        dec_restore  = 1'b0;
        dec_kind     = EV_RETIRED;
        dec_new      = cur_q;
        dec_num      = cur_num;
        dec_mov_role = ROLE_CP;
        dec_mov_num  = cur_num;
        unique case (cur_role)
            ROLE_CP: begin
                dec_evt  = 1'b1;
                dec_fail = 1'b1;
                if (spare_found) begin
                    dec_mov     = 1'b1;
                    dec_restore = 1'b1;
                    dec_kind    = EV_CP_SPARED;
                    dec_new     = spare_idx;
                end else begin
                    dec_lost = 1'b1;
                    dec_kind = EV_CP_LOST;
                end
            end
            ROLE_ASSIST: begin
                dec_evt      = 1'b1;
                dec_fail     = 1'b1;
                dec_mov_role = ROLE_ASSIST;
                if (spare_found) begin
                    dec_mov  = 1'b1;
                    dec_kind = EV_ASSIST_SPARED;
                    dec_new  = spare_idx;
                end else if (cur_num == '0) begin
                    if (cp_found) begin
                        dec_mov     = 1'b1;
                        dec_kind    = EV_ASSIST_FROM_CP;
                        dec_new     = cp_idx;
                        dec_num     = nums_i[cp_idx];
                        dec_mov_num = '0;
                    end else begin
                        dec_lost = 1'b1;
                        dec_kind = EV_CP_LOST;
                    end
                end
            end
            ROLE_SPARE: begin
                dec_evt  = 1'b1;
                dec_fail = 1'b1;
            end
            default: begin
                dec_evt = 1'b0;
            end
        endcase
    end

    assign upd_en   = commit && dec_fail;
    assign upd_unit = cur_q;
    assign mov_en   = commit && dec_mov;
    assign mov_unit = dec_new;
    assign mov_role = dec_mov_role;
    assign mov_num  = dec_mov_num;

    // Registered event outputs, one pulse per completed report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid    <= 1'b0;
            evt_kind_q   <= EV_CP_SPARED;
            evt_old_unit <= '0;
            evt_new_unit <= '0;
            evt_num      <= '0;
            restore_req  <= 1'b0;
        end else begin
            evt_valid   <= commit && dec_evt;
            restore_req <= commit && dec_restore;
            if (commit && dec_evt) begin
                evt_kind_q   <= dec_kind;
                evt_old_unit <= cur_q;
                evt_new_unit <= dec_new;
                evt_num      <= dec_num;
            end
        end
    end

    // Sticky loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) unrec_q <= 1'b0;
        else if (commit && dec_lost) unrec_q <= 1'b1;
    end

    assign evt_kind      = evt_kind_q;
    assign unrecoverable = unrec_q;

    // Busy run-length counter, used only by the window check.
    logic [CW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_q) run_q <= '0;
        else if (run_q != CW'(PROC_CYCLES)) run_q <= run_q + 1'b1;
    end

    p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_valid && fail_ready) |=> !fail_ready);
    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (run_q < CW'(PROC_CYCLES)));
    p_pick_spare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spare_found |-> (roles_i[spare_idx] == ROLE_SPARE));
    p_restore_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> (evt_valid && (evt_kind_q == EV_CP_SPARED)));
    p_convert_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mov_en && (dec_kind == EV_ASSIST_FROM_CP)) |-> (roles_i[mov_unit] == ROLE_CP));
    p_unrec_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unrecoverable |=> unrecoverable);
    p_evt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

endmodule

// File: rtl/proc_sparing_mgr.sv
// Module: proc_sparing_mgr (top)
// Transparent processor sparing manager. It ties together the role table,
// the spare/processor search and the report sequencer. It also provides a
// combinational query port into the table.
// Assumes: NUM_UNITS is a power of two, and the parameter tables hold
// valid role codes.
module proc_sparing_mgr #(
    parameter int NUM_UNITS   = 16,
    parameter int NUM_W       = 4,
    parameter int PROC_CYCLES = 4,
    parameter logic [2*NUM_UNITS-1:0]     INIT_ROLES = 32'h6A01_4000,
    parameter logic [NUM_W*NUM_UNITS-1:0] INIT_NUMS  = 64'h2000_9871_0654_3210,
    localparam int UW = $clog2(NUM_UNITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_valid,
    input  logic [UW-1:0]    fail_unit,
    output logic             fail_ready,
    input  logic [UW-1:0]    qry_unit,
    output logic [1:0]       qry_role,
    output logic [NUM_W-1:0] qry_num,
    output logic             evt_valid,
    output logic [2:0]       evt_kind,
    output logic [UW-1:0]    evt_old_unit,
    output logic [UW-1:0]    evt_new_unit,
    output logic [NUM_W-1:0] evt_num,
    output logic             restore_req,
    output logic             unrecoverable
);
    logic [NUM_UNITS-1:0][1:0]       roles;
    logic [NUM_UNITS-1:0][NUM_W-1:0] nums;
    logic             spare_found, cp_found;
    logic [UW-1:0]    spare_idx, cp_idx;
    logic             upd_en, mov_en;
    logic [UW-1:0]    upd_unit, mov_unit;
    logic [1:0]       mov_role;
    logic [NUM_W-1:0] mov_num;

    spare_role_table #(
        .N(NUM_UNITS), .UW(UW), .NW(NUM_W),
        .INIT_ROLES(INIT_ROLES), .INIT_NUMS(INIT_NUMS)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .upd_en(upd_en), .upd_unit(upd_unit),
        .mov_en(mov_en), .mov_unit(mov_unit),
        .mov_role(mov_role), .mov_num(mov_num),
        .roles_o(roles), .nums_o(nums)
    );

    spare_pick #(.N(NUM_UNITS), .UW(UW)) u_pick (
        .roles_i(roles),
        .spare_found(spare_found), .spare_idx(spare_idx),
        .cp_found(cp_found), .cp_idx(cp_idx)
    );

    spare_sequencer #(
        .N(NUM_UNITS), .UW(UW), .NW(NUM_W), .PROC_CYCLES(PROC_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .fail_valid(fail_valid), .fail_unit(fail_unit), .fail_ready(fail_ready),
        .roles_i(roles), .nums_i(nums),
        .spare_found(spare_found), .spare_idx(spare_idx),
        .cp_found(cp_found), .cp_idx(cp_idx),
        .upd_en(upd_en), .upd_unit(upd_unit),
        .mov_en(mov_en), .mov_unit(mov_unit),
        .mov_role(mov_role), .mov_num(mov_num),
        .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_old_unit(evt_old_unit), .evt_new_unit(evt_new_unit),
        .evt_num(evt_num), .restore_req(restore_req),
        .unrecoverable(unrecoverable)
    );

    // Query port: direct read of the table (R2).
    assign qry_role = roles[qry_unit];
    assign qry_num  = nums[qry_unit];

endmodule

// File: tb/proc_sparing_mgr_tb.sv
// Scoreboard bench for proc_sparing_mgr. The driver task pushes the
// expected events, and a monitor pops and compares them as they appear.
module proc_sparing_mgr_tb_top;

    localparam int PC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fail_valid = 1'b0;
    logic [3:0] fail_unit = '0;
    logic [3:0] qry_unit = '0;
    logic       fail_ready, evt_valid, restore_req, unrecoverable;
    logic [1:0] qry_role;
    logic [3:0] qry_num, evt_old_unit, evt_new_unit, evt_num;
    logic [2:0] evt_kind;

    always #4 clk = ~clk;

    proc_sparing_mgr #(.PROC_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fail_valid(fail_valid), .fail_unit(fail_unit), .fail_ready(fail_ready),
        .qry_unit(qry_unit), .qry_role(qry_role), .qry_num(qry_num),
        .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_old_unit(evt_old_unit), .evt_new_unit(evt_new_unit),
        .evt_num(evt_num), .restore_req(restore_req),
        .unrecoverable(unrecoverable)
    );

    typedef struct {
        int kind; int old_u; int new_u; int num; int rst; int qrole; string tag;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Initial table as seen from outside: role codes and numbers per unit.
    int init_role[16] = '{0,0,0,0,0,0,0,1,1,0,0,0,2,2,2,1};
    int init_num[16]  = '{0,1,2,3,4,5,6,0,1,7,8,9,0,0,0,2};

    task automatic check(input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Driver: present one report and push the expected event. Then check
    // the busy window length and the timing of the event pulse.
    task automatic report(input int unit, input bit has_evt, input int kind,
                          input int new_u, input int num, input int rst,
                          input int qrole, input string tag);
        exp_t e;
        int busy;
        qry_unit = 4'(new_u);
        @(negedge clk);
        while (!fail_ready) @(negedge clk);
        if (has_evt) begin
            e.kind = kind; e.old_u = unit; e.new_u = new_u; e.num = num;
            e.rst = rst; e.qrole = qrole; e.tag = tag;
            exp_q.push_back(e);
        end
        fail_valid = 1'b1;
        fail_unit  = 4'(unit);
        @(negedge clk);
        fail_valid = 1'b0;
        busy = 0;
        while (!fail_ready) begin
            busy++;
            @(negedge clk);
        end
        check("R3", "busy cycles", busy, PC);
        check("R10", "event with ready", int'(evt_valid), int'(has_evt));
        @(negedge clk);
        check("R10", "event single cycle", int'(evt_valid), 0);
    endtask

    // Monitor: pop and compare each event, including the same-cycle query.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && evt_valid) begin
                if (exp_q.size() == 0) begin
                    check("R5", "unexpected event kind", int'(evt_kind), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, "evt_kind", int'(evt_kind), e.kind);
                    check(e.tag, "evt_old_unit", int'(evt_old_unit), e.old_u);
                    check(e.tag, "evt_new_unit", int'(evt_new_unit), e.new_u);
                    check(e.tag, "evt_num", int'(evt_num), e.num);
                    check(e.tag, "restore_req", int'(restore_req), e.rst);
                    check("R10", "query role in event cycle", int'(qry_role), e.qrole);
                end
            end else if (rst_n) begin
                check("R4", "restore without event", int'(restore_req), 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R2: reset contents through the query port.
        check("R1", "fail_ready", int'(fail_ready), 1);
        check("R1", "evt_valid", int'(evt_valid), 0);
        check("R1", "restore_req", int'(restore_req), 0);
        check("R1", "unrecoverable", int'(unrecoverable), 0);
        for (int u = 0; u < 16; u++) begin
            qry_unit = 4'(u);
            #1;
            check("R2", "reset role", int'(qry_role), init_role[u]);
            check("R2", "reset num", int'(qry_num), init_num[u]);
        end

        // R4: logical unit 3 (number 3) fails; spare 12 takes over.
        report(3, 1, 0, 12, 3, 1, 0, "R4");
        qry_unit = 4'd12; #1;
        check("R4", "spare takes number", int'(qry_num), 3);
        qry_unit = 4'd3; #1;
        check("R5", "failed unit role", int'(qry_role), 3);

        // R6: master assist unit 7 fails; lowest spare 13 becomes assist 0.
        report(7, 1, 1, 13, 0, 0, 1, "R6");
        qry_unit = 4'd13; #1;
        check("R6", "assist index kept", int'(qry_num), 0);

        // R9: a spare fails.
        report(14, 1, 4, 14, 0, 0, 3, "R9");
        // R9: non-master assist 15 fails with no spare left.
        report(15, 1, 4, 15, 2, 0, 3, "R9");
        check("R8", "no loss yet", int'(unrecoverable), 0);

        // R7: master assist 13 fails, no spare: highest logical unit 12 (number 3) converts.
        report(13, 1, 2, 12, 3, 0, 1, "R7");
        qry_unit = 4'd12; #1;
        check("R7", "converted unit index", int'(qry_num), 0);

        // R8: logical unit 5 fails with no spare.
        report(5, 1, 3, 5, 5, 0, 3, "R8");
        check("R8", "unrecoverable set", int'(unrecoverable), 1);

        // R5: report on an already failed unit does nothing.
        report(5, 0, 0, 5, 0, 0, 0, "R5");
        qry_unit = 4'd5; #1;
        check("R5", "still failed", int'(qry_role), 3);
        check("R5", "number untouched", int'(qry_num), 5);
        qry_unit = 4'd3; #1;
        check("R5", "old failed unit not reused", int'(qry_role), 3);

        // R3: a second report held on fail_valid while busy.
        qry_unit = 4'd9;
        @(negedge clk);
        exp_q.push_back('{3, 9, 9, 7, 0, 3, "R3"});
        exp_q.push_back('{3, 10, 10, 8, 0, 3, "R3"});
        fail_valid = 1'b1;
        fail_unit  = 4'd9;
        @(negedge clk);
        fail_unit = 4'd10;
        k = 1;
        while (!fail_ready) begin
            k++;
            @(negedge clk);
        end
        check("R3", "held report wait", k, PC + 1);
        @(negedge clk);
        fail_valid = 1'b0;
        check("R3", "held report taken", int'(fail_ready), 0);
        while (!fail_ready) @(negedge clk);
        @(negedge clk);
        check("R8", "flag still set", int'(unrecoverable), 1);
        check("R3", "all events seen", exp_q.size(), 0);
        qry_unit = 4'd12; #1;
        check("R2", "converted unit role", int'(qry_role), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule